// File: doc/BRIEF.md
# Page Write Buffer with Self-Timed Commit

This block sits behind a serial-memory protocol engine and gathers the data bytes of one write command for a single page of the array. The engine first loads a word address. Its upper bits select the page, and its lower `IDX_W` bits give the starting slot. Each data byte that follows lands in the slot under the pointer, and then the pointer steps forward within the page. A per-slot valid mask records which locations this command has touched.

When the engine reports the STOP condition and at least one byte has been received, the block starts a self-timed write cycle. `busy_o` rises and stays high for exactly `BUSY_CYCLES` clocks. During the first `2**IDX_W` cycles of that window, the buffer is swept in ascending slot order, and every valid slot is presented on the RAM write port. The valid mask clears as the window closes. Address loads, data bytes and STOP are refused while busy. A protocol engine can poll `busy_o` to decide whether to acknowledge.

`BUSY_CYCLES` must be at least `2**IDX_W`. Simulation uses a short value, while silicon would use the clock count of the nominal 1 ms cycle.

Top module: `page_write_buffer`

## Requirements
- R1: After reset, `busy_o` is 0, `mem_we_o` is 0, and the valid mask is empty.
- R2: A byte received with the pointer at slot i is committed to address {page, i}. The page is the upper `ADDR_W-IDX_W` bits of the last loaded address. Only the low `IDX_W` bits advance per byte, so slot 15 is followed by slot 0 of the same page.
- R3: When more than 16 bytes arrive before STOP, later bytes overwrite earlier ones slot by slot, and the committed value of each slot is the last byte written to it.
- R4: `mem_we_o` is never asserted while `busy_o` is low, so nothing reaches the array before STOP.
- R5: A STOP while idle, with at least one valid slot, raises `busy_o` on the following cycle. `busy_o` then stays high for exactly `BUSY_CYCLES` cycles.
- R6: During a commit, each valid slot is written exactly once and no invalid slot is written. Writes occur in ascending slot order within the first `2**IDX_W` busy cycles.
- R7: A STOP with an empty valid mask starts no write cycle: `busy_o` stays 0 and no write occurs.
- R8: Address loads and data bytes presented while `busy_o` is high are ignored. A STOP directly after the busy window, with no new bytes, therefore starts no cycle.
- R9: The valid mask is empty when `busy_o` falls, so the next command commits only its own bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_load_i | input | 1 | Load word address (one-cycle pulse) |
| addr_i | input | ADDR_W | Word address: page in upper bits, slot in low IDX_W bits |
| data_valid_i | input | 1 | Data byte strobe |
| data_i | input | DATA_W | Data byte |
| stop_i | input | 1 | STOP condition seen by the protocol engine |
| busy_o | output | 1 | Write cycle in progress |
| mem_we_o | output | 1 | RAM write enable |
| mem_addr_o | output | ADDR_W | RAM write address |
| mem_wdata_o | output | DATA_W | RAM write data |

## Verification
The assertions assume the following about the inputs. `addr_load_i`, `data_valid_i` and `stop_i` are one-cycle pulses that never coincide. `BUSY_CYCLES` is at least the page depth. A STOP arrives only after the bytes it closes have been strobed. The stimulus drives each strobe alone for a single cycle at the falling edge, with random addresses, byte counts from 0 to 40 and random data. Directed cases cover a page-end wrap, a 20-byte overwrite, an empty command, and address and data strobes injected in the middle of the busy window.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam int unsigned PWB_DATA_W = 8;

  function automatic int unsigned pwb_tmr_w(input int unsigned cycles);
    return (cycles < 2) ? 1 : $clog2(cycles + 1);
  endfunction
endpackage

// File: rtl/pwb_page_store.sv
module pwb_page_store #(
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned PAGE_W = 3,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned DEPTH = 1 << IDX_W,
  localparam int unsigned ADDR_W = PAGE_W + IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              clr_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [PAGE_W-1:0] page_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DEPTH-1:0]  valid_o
);
  logic [IDX_W-1:0]  ptr_q;
  logic [PAGE_W-1:0] page_q;
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [DEPTH-1:0]  valid_q;
  logic              store;

  assign store = wr_i && !load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      page_q <= '0;
    end else if (load_i) begin
      page_q <= addr_i[ADDR_W-1:IDX_W];
      ptr_q  <= addr_i[IDX_W-1:0];
    end else if (wr_i) begin
      ptr_q  <= ptr_q + 1'b1;  // low bits wrap inside the page
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic hit;
    assign hit = store && (ptr_q == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  data_q[g] <= '0;
      else if (hit) data_q[g] <= data_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              valid_q[g] <= 1'b0;
      else if (clr_i || load_i) valid_q[g] <= 1'b0;
      else if (hit)             valid_q[g] <= 1'b1;
    end
  end

  assign page_o    = page_q;
  assign valid_o   = valid_q;
  assign rd_data_o = data_q[rd_idx_i];
endmodule

// File: rtl/pwb_busy_timer.sv
module pwb_busy_timer #(
  parameter int unsigned BUSY_CYCLES = 40,
  parameter int unsigned IDX_W       = 4,
  localparam int unsigned DEPTH = 1 << IDX_W,
  localparam int unsigned TMR_W = pwb_pkg::pwb_tmr_w(BUSY_CYCLES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic             scan_en_o,
  output logic [IDX_W-1:0] scan_idx_o,
  output logic             done_o
);
  logic [TMR_W-1:0] timer_q;
  logic             busy_q;

  assign done_o = busy_q && (timer_q == TMR_W'(BUSY_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      timer_q <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q  <= 1'b1;
        timer_q <= '0;
      end
    end else if (done_o) begin
      busy_q  <= 1'b0;
      timer_q <= '0;
    end else begin
      timer_q <= timer_q + 1'b1;
    end
  end

  // sweep slots during the first DEPTH busy cycles
  assign busy_o     = busy_q;
  assign scan_en_o  = busy_q && (32'(timer_q) < DEPTH);
  assign scan_idx_o = timer_q[IDX_W-1:0];
endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer #(
  parameter int unsigned ADDR_W      = 7,
  parameter int unsigned IDX_W       = 4,
  parameter int unsigned DATA_W      = pwb_pkg::PWB_DATA_W,
  parameter int unsigned BUSY_CYCLES = 40,
  localparam int unsigned DEPTH  = 1 << IDX_W,
  localparam int unsigned PAGE_W = ADDR_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              data_valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              stop_i,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  logic              busy, start, done, scan_en;
  logic [IDX_W-1:0]  scan_idx;
  logic [PAGE_W-1:0] page;
  logic [DATA_W-1:0] rd_data;
  logic [DEPTH-1:0]  valid;

  assign start = stop_i && !busy && (|valid);

  pwb_page_store #(
    .IDX_W (IDX_W),
    .PAGE_W(PAGE_W),
    .DATA_W(DATA_W)
  ) i_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (addr_load_i && !busy),
    .addr_i   (addr_i),
    .wr_i     (data_valid_i && !busy),
    .data_i   (data_i),
    .clr_i    (done),
    .rd_idx_i (scan_idx),
    .page_o   (page),
    .rd_data_o(rd_data),
    .valid_o  (valid)
  );

  pwb_busy_timer #(
    .BUSY_CYCLES(BUSY_CYCLES),
    .IDX_W      (IDX_W)
  ) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .busy_o    (busy),
    .scan_en_o (scan_en),
    .scan_idx_o(scan_idx),
    .done_o    (done)
  );

  assign busy_o      = busy;
  assign mem_we_o    = scan_en && valid[scan_idx];
  assign mem_addr_o  = {page, scan_idx};
  assign mem_wdata_o = rd_data;

  AST_WE_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o);  // R4
  AST_BUSY_FROM_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(stop_i));  // R5
  AST_EMPTY_NO_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !busy_o && valid == '0) |=> !busy_o);  // R7
  AST_MASK_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done) |=> $stable(valid));  // R8
  AST_WE_ASCENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && $past(mem_we_o)) |-> mem_addr_o[IDX_W-1:0] > $past(mem_addr_o[IDX_W-1:0]));  // R6
  AST_PAGE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(mem_addr_o[ADDR_W-1:IDX_W]));  // R2
  AST_MASK_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> valid == '0);  // R9
endmodule

// File: tb/test_page_write_buffer.sv
`timescale 1ns/1ps
module test_page_write_buffer;
  localparam int AW = 7, IW = 4, DW = 8, BC = 24, DEPTH = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic addr_load = 0, data_valid = 0, stop = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic busy, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;

  int checks = 0, errors = 0;
  logic [DW-1:0] exp_data [DEPTH];
  bit exp_valid [DEPTH];
  int exp_page = 0, exp_ptr = 0;
  int got_addr [64];
  int got_data [64];

  always #5 clk = ~clk;

  page_write_buffer #(.ADDR_W(AW), .IDX_W(IW), .DATA_W(DW), .BUSY_CYCLES(BC)) i_page_write_buffer (
    .clk_i(clk), .rst_ni(rst_n), .addr_load_i(addr_load), .addr_i(addr),
    .data_valid_i(data_valid), .data_i(data), .stop_i(stop), .busy_o(busy),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && mem_we && !busy) chk(0, "R4 write while idle", 1, 0);

  task automatic load(input int a);
    addr_load = 1; addr = AW'(a);
    @(negedge clk); addr_load = 0;
    exp_page = a >> IW; exp_ptr = a & (DEPTH - 1);
    for (int i = 0; i < DEPTH; i++) exp_valid[i] = 0;
  endtask

  task automatic send(input int d);
    data_valid = 1; data = DW'(d);
    @(negedge clk); data_valid = 0;
    exp_data[exp_ptr] = DW'(d); exp_valid[exp_ptr] = 1;
    exp_ptr = (exp_ptr + 1) % DEPTH;
  endtask

  task automatic commit(input bit expect_busy, input bit inject);
    int cnt = 0, ngot = 0, nexp = 0;
    stop = 1;
    @(negedge clk); stop = 0;
    while (busy && cnt < BC + 8) begin
      if (mem_we && ngot < 64) begin
        got_addr[ngot] = int'(mem_addr); got_data[ngot] = int'(mem_wdata); ngot++;
      end
      if (inject && cnt == 2) begin data_valid = 1; data = 8'hA5; end
      if (inject && cnt == 3) begin data_valid = 0; addr_load = 1; addr = 7'h05; end
      if (inject && cnt == 4) addr_load = 0;
      cnt++;
      @(negedge clk);
    end
    if (expect_busy) chk(cnt == BC, "R5 busy length", cnt, BC);
    else             chk(cnt == 0, "R7 empty stop busy", cnt, 0);
    for (int i = 0; i < DEPTH; i++) if (exp_valid[i]) begin
      if (nexp < ngot) begin
        chk(got_addr[nexp] == exp_page * DEPTH + i, "R2 commit address", got_addr[nexp], exp_page * DEPTH + i);
        chk(got_data[nexp] == int'(exp_data[i]), "R3 commit data", got_data[nexp], int'(exp_data[i]));
      end
      nexp++;
    end
    chk(ngot == nexp, "R6 write count", ngot, nexp);
    for (int i = 0; i < DEPTH; i++) exp_valid[i] = 0;  // R9: mask empty after commit
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1c0ffee));
    for (int i = 0; i < DEPTH; i++) exp_valid[i] = 0;
    repeat (3) @(negedge clk);
    chk(busy == 0, "R1 busy in reset", int'(busy), 0);
    chk(mem_we == 0, "R1 we in reset", int'(mem_we), 0);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0, "R1 busy after reset", int'(busy), 0);
    // R1: empty mask after reset -> stop starts nothing
    commit(0, 0);
    // single byte
    load(7'h23); send(8'h3C); commit(1, 0);
    // R2: wrap from slot 15 to slot 0 in page 7
    load(7'h7E); for (int i = 0; i < 4; i++) send(8'h10 + i); commit(1, 0);
    // R3: 20 bytes, the last four overwrite the first four slots used
    load(7'h15); for (int i = 0; i < 20; i++) send(i * 7 + 1); commit(1, 0);
    // R7: address only
    load(7'h40); commit(0, 0);
    // R8: strobes during busy ignored, then R9 only new bytes committed
    load(7'h30); send(8'h11); send(8'h22); commit(1, 1);
    commit(0, 0);
    load(7'h30); send(8'h99); commit(1, 0);
    // constrained random commands
    for (int t = 0; t < 30; t++) begin
      int n = $urandom_range(0, 40);
      load($urandom_range(0, 127));
      for (int k = 0; k < n; k++) send($urandom_range(0, 255));
      commit(n > 0, 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule